// File: doc/BRIEF.md
# Parallel-Pair Next-PC Sequencer

This block owns the program counter of a core that issues either one instruction or a pair of instructions per group. After a group has executed, the execute stage presents one strobe. With it come the group size, the result class reported by the first instruction and that instruction's branch target. On that clock edge the block picks the next program counter.

The block also tells the execute stage whether the second slot of a pair must be annulled. It pulses once for every executed pair and keeps a wrapping count of those pairs. A taken branch in the first slot of a pair does not annul its partner. The redirect is applied only after both instructions have run. Only a skip-class first instruction annuls the partner. The second slot never influences the program counter.

The group interface has no back-pressure. The sequencer accepts a group in every cycle in which `grp_valid` is high, so there is no ready signal, and the result is committed on that same edge. When `grp_valid` is low the group inputs are don't-care and nothing changes.

Top module: `npc_sequencer`

## Requirements
- R1: While `rst_n` is low, `pc_q` is forced to the parameter `RESET_PC` and `pair_count` is forced to zero. Both values hold on the first edge after release if no group is offered.
- R2: When `grp_class` is 01 (4-byte sequential), the next PC is PC+4, for both a single (`grp_pair`=0) and a pair (`grp_pair`=1). `slot2_kill` stays low.
- R3: When `grp_pair`=1 and `grp_class` is 10 (skip), `slot2_kill` is high in that cycle and the next PC is PC+4.
- R4: When `grp_pair`=1 and `grp_class` is 00 (2-byte) or 11 (branch taken), `slot2_kill` is low. The next PC is `grp_target` for class 11 and PC+4 for class 00.
- R5: When `grp_pair`=0, class 11 loads `grp_target`, while classes 00 and 10 advance the PC by 2. `slot2_kill` stays low.
- R6: Each accepted pair raises `pair_pulse` for that cycle and adds one to `pair_count` on the edge, whether or not the partner was annulled. The count wraps from all ones to zero.
- R7: With `grp_valid` low, `pc_q` and `pair_count` keep their values, and `slot2_kill` and `pair_pulse` are low.
- R8: `next_pc` shows in the same cycle the value that `pc_q` takes at the next edge when `grp_valid` is high. PC arithmetic wraps modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_valid | input | 1 | An issue group finished executing this cycle |
| grp_pair | input | 1 | 1 = two instructions issued, 0 = one |
| grp_class | input | 2 | First-slot result: 00 2-byte, 01 4-byte, 10 skip, 11 branch taken |
| grp_target | input | AW | First-slot branch target |
| pc_q | output | AW | Current program counter |
| next_pc | output | AW | Program counter selected for the coming edge |
| slot2_kill | output | 1 | Annul the second slot of this pair |
| pair_pulse | output | 1 | One executed pair accepted this cycle |
| pair_count | output | CW | Wrapping count of executed pairs |

## Verification
The properties assume that `grp_class` and `grp_pair` are never unknown while `grp_valid` is high. They also assume that the target only matters for class 11, so a target given with any other class must leave the PC untouched. The stimulus drives every input on the falling edge and keeps it stable through the next rising edge. It sweeps all group sizes and all four classes from several start addresses, including addresses next to the wrap point, and puts idle cycles between groups with random targets on the bus.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [1:0] {
    RC_SEQ2   = 2'b00,
    RC_SEQ4   = 2'b01,
    RC_SKIP   = 2'b10,
    RC_BRANCH = 2'b11
  } res_class_e;
endpackage

// File: rtl/npc_resolve.sv
module npc_resolve
  import npc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          grp_valid,
  input  logic          grp_pair,
  input  res_class_e    grp_class,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] target,
  output logic [AW-1:0] nxt,
  output logic          kill,
  output logic          pair_evt
);
  localparam logic [AW-1:0] STEP_HALF = AW'(2);
  localparam logic [AW-1:0] STEP_FULL = AW'(4);

  logic [AW-1:0] pc_plus2;
  logic [AW-1:0] pc_plus4;

  assign pc_plus2 = pc + STEP_HALF;
  assign pc_plus4 = pc + STEP_FULL;

  // The second slot's own result never takes part in this selection.
  always_comb begin
    nxt      = pc;
    kill     = 1'b0;
    pair_evt = 1'b0;
    if (grp_valid) begin
      pair_evt = grp_pair;
      if (grp_class == RC_SEQ4) begin
        nxt = pc_plus4;
      end else if (grp_pair) begin
        if (grp_class == RC_SKIP) begin
          kill = 1'b1;
          nxt  = pc_plus4;
        end else if (grp_class == RC_BRANCH) begin
          nxt = target;
        end else begin
          nxt = pc_plus4;
        end
      end else if (grp_class == RC_BRANCH) begin
        nxt = target;
      end else begin
        nxt = pc_plus2;
      end
    end
  end
endmodule

// File: rtl/npc_pc_reg.sv
module npc_pc_reg #(
  parameter int            AW       = 32,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] d,
  output logic [AW-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= RESET_PC;
    else if (load) q <= d;
  end
endmodule

// File: rtl/npc_pair_counter.sv
module npc_pair_counter #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] ONE = CW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= count + ONE;
  end
endmodule

// File: rtl/npc_sequencer.sv
module npc_sequencer
  import npc_pkg::*;
#(
  parameter int            AW       = 32,
  parameter int            CW       = 32,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          grp_valid,
  input  logic          grp_pair,
  input  logic [1:0]    grp_class,
  input  logic [AW-1:0] grp_target,
  output logic [AW-1:0] pc_q,
  output logic [AW-1:0] next_pc,
  output logic          slot2_kill,
  output logic          pair_pulse,
  output logic [CW-1:0] pair_count
);
  res_class_e cls;
  assign cls = res_class_e'(grp_class);

  npc_resolve #(.AW(AW)) u_resolve (
    .grp_valid (grp_valid),
    .grp_pair  (grp_pair),
    .grp_class (cls),
    .pc        (pc_q),
    .target    (grp_target),
    .nxt       (next_pc),
    .kill      (slot2_kill),
    .pair_evt  (pair_pulse)
  );

  npc_pc_reg #(.AW(AW), .RESET_PC(RESET_PC)) u_pc (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (grp_valid),
    .d     (next_pc),
    .q     (pc_q)
  );

  npc_pair_counter #(.CW(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (pair_pulse),
    .count (pair_count)
  );
endmodule

// File: rtl/npc_sequencer_chk.sv
module npc_sequencer_chk #(
  parameter int AW = 32,
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          grp_valid,
  input logic          grp_pair,
  input logic [1:0]    grp_class,
  input logic [AW-1:0] grp_target,
  input logic [AW-1:0] pc_q,
  input logic [AW-1:0] next_pc,
  input logic          slot2_kill,
  input logic          pair_pulse,
  input logic [CW-1:0] pair_count
);
  a_r2_seq4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_valid && grp_class == 2'b01) |=> (pc_q == $past(pc_q) + AW'(4)));

  a_r3_skip_kill: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_valid && grp_pair && grp_class == 2'b10) |-> slot2_kill);

  a_r4_pair_branch: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_valid && grp_pair && grp_class == 2'b11) |=> (pc_q == $past(grp_target)));

  a_r5_single_branch: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_valid && !grp_pair && grp_class == 2'b11) |=> (pc_q == $past(grp_target)));

  a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    pair_pulse |=> (pair_count == $past(pair_count) + CW'(1)));

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_valid |=> ($stable(pc_q) && $stable(pair_count)));

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_valid |-> (!slot2_kill && !pair_pulse));

  a_r8_preview: assert property (@(posedge clk) disable iff (!rst_n)
    grp_valid |=> (pc_q == $past(next_pc)));
endmodule

bind npc_sequencer npc_sequencer_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .grp_valid  (grp_valid),
  .grp_pair   (grp_pair),
  .grp_class  (grp_class),
  .grp_target (grp_target),
  .pc_q       (pc_q),
  .next_pc    (next_pc),
  .slot2_kill (slot2_kill),
  .pair_pulse (pair_pulse),
  .pair_count (pair_count)
);

// File: tb/npc_sequencer_tb.sv
module npc_sequencer_tb;
  localparam int          AW   = 32;
  localparam int          CW   = 4;
  localparam logic [31:0] RVEC = 32'h0000_1000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          grp_valid = 1'b0;
  logic          grp_pair = 1'b0;
  logic [1:0]    grp_class = 2'b00;
  logic [AW-1:0] grp_target = '0;
  logic [AW-1:0] pc_q, next_pc;
  logic          slot2_kill, pair_pulse;
  logic [CW-1:0] pair_count;

  int errors = 0;
  int checks = 0;
  logic [AW-1:0] m_pc;
  logic [CW-1:0] m_cnt;

  always #2.5 clk = ~clk;

  npc_sequencer #(.AW(AW), .CW(CW), .RESET_PC(RVEC)) u_dut (
    .clk(clk), .rst_n(rst_n), .grp_valid(grp_valid), .grp_pair(grp_pair),
    .grp_class(grp_class), .grp_target(grp_target), .pc_q(pc_q),
    .next_pc(next_pc), .slot2_kill(slot2_kill), .pair_pulse(pair_pulse),
    .pair_count(pair_count));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // One accepted group: inputs set at the falling edge, previews checked
  // before the rising edge, registered state checked after it.
  task automatic run_group(input logic pr, input logic [1:0] cl, input logic [AW-1:0] tg);
    logic [AW-1:0] e_pc;
    logic          e_kill;
    string         rq;
    @(negedge clk);
    grp_valid = 1'b1; grp_pair = pr; grp_class = cl; grp_target = tg;
    e_kill = 1'b0;
    if (cl == 2'b01) begin
      e_pc = m_pc + 4; rq = "R2";
    end else if (pr) begin
      rq = "R4";
      if (cl == 2'b10) begin e_pc = m_pc + 4; e_kill = 1'b1; rq = "R3"; end
      else if (cl == 2'b11) e_pc = tg;
      else e_pc = m_pc + 4;
    end else begin
      rq = "R5";
      e_pc = (cl == 2'b11) ? tg : m_pc + 2;
    end
    #1;
    chk({rq, " kill"}, {31'd0, slot2_kill}, {31'd0, e_kill});
    chk("R6 pulse", {31'd0, pair_pulse}, {31'd0, pr});
    chk("R8 preview", next_pc, e_pc);
    @(posedge clk); #1;
    m_pc = e_pc;
    if (pr) m_cnt = m_cnt + 1'b1;
    chk({rq, " pc"}, pc_q, m_pc);
    chk("R6 count", {28'd0, pair_count}, {28'd0, m_cnt});
  endtask

  task automatic idle_cycle(input logic [AW-1:0] junk);
    @(negedge clk);
    grp_valid = 1'b0; grp_pair = junk[0]; grp_class = junk[2:1]; grp_target = junk;
    #1;
    chk("R7 kill", {31'd0, slot2_kill}, 32'd0);
    chk("R7 pulse", {31'd0, pair_pulse}, 32'd0);
    @(posedge clk); #1;
    chk("R7 pc", pc_q, m_pc);
    chk("R7 count", {28'd0, pair_count}, {28'd0, m_cnt});
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [AW-1:0] starts [4];
    starts[0] = 32'h0000_2000; starts[1] = 32'hFFFF_FFFC;
    starts[2] = 32'hFFFF_FFFE; starts[3] = 32'h1234_5676;
    m_pc = RVEC; m_cnt = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 pc", pc_q, RVEC);
    chk("R1 count", {28'd0, pair_count}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 hold pc", pc_q, RVEC);
    chk("R1 hold count", {28'd0, pair_count}, 32'd0);
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 2; p++) begin
        for (int c = 0; c < 4; c++) begin
          for (int t = 0; t < 3; t++) begin
            run_group(1'b0, 2'b11, starts[s]);
            run_group(p[0], c[1:0], $urandom());
            if (t == 1) idle_cycle($urandom());
          end
        end
      end
    end
    // R6: wrap of the pair count from all ones back to zero.
    while (m_cnt != '1) run_group(1'b1, 2'b00, '0);
    run_group(1'b1, 2'b10, '0);
    chk("R6 wrap", {28'd0, pair_count}, 32'd0);
    idle_cycle(32'hFFFF_FFFF);
    finish_run();
  end
endmodule